// File: doc/BRIEF.md
# Configurable macrocell register and output stage

This block is the storage and output half of one programmable logic cell. It takes the already-formed logic results of the cell (the XOR result, a spare data term, a second control term and several control terms) together with the raw pin input, a set of global clocks, a global clear and dedicated enable pins. Static configuration inputs decide what the single storage element captures, how it behaves, what clocks it, what clears or sets it, and what reaches the pad and the internal feedback path.

The stage is meant for an FPGA fabric. Every signal is sampled on one system clock `clk`. The cell clocks are treated as data. A rising edge of the selected cell clock is a system cycle in which that clock reads 1 after it read 0 in the previous cycle. Clear and preset are level inputs that act in any system cycle, whatever the selected cell clock is doing. All three outputs are registered, so each output shows the effect of a system cycle's inputs one `clk` edge later.

Top module: `mc_stage`

## Requirements
- R1: While `rst` is high at a `clk` edge, the stored state, the remembered clock levels, `pad_out`, `pad_oe` and `fb_out` all become 0 after that edge.
- R2: `cfg_dsrc` picks the storage data input d: 0 gives `xor_in`, 1 gives `pt_data`, 2 gives `pin_in`, and 3 also gives `xor_in`.
- R3: `cfg_csrc` values 0 to NGCK-1 select `gclk[cfg_csrc]` and value NGCK selects `pt_clk`. In mode 0 (D), the state takes d on each rising edge of the selected clock and holds at every other time.
- R4: In mode 1 (T), a rising edge inverts the state when d is 1 and keeps it when d is 0.
- R5: In mode 2 (JK), d acts as J and `pt_k` as K. On a rising edge, 10 sets the state, 01 clears it, 11 inverts it and 00 keeps it.
- R6: In mode 3 (SR), d acts as S and `pt_k` as R. On a rising edge, 10 sets the state, 01 clears it, and 00 or 11 keep it. Modes 5 to 7 behave as mode 0.
- R7: In mode 4 (latch), the state follows d in every cycle in which the selected clock is high, and it holds while that clock is low.
- R8: When a global clock is selected and `cfg_cen` is 1, a low `pt_cen` blocks rising edges in the flip-flop modes and blocks transparency in latch mode. When `pt_clk` is selected, `pt_cen` has no effect.
- R9: `cfg_ar` bit 0 lets `gclr` clear the state and bit 1 lets `pt_ar` clear it. With both bits set, either input clears it. A clear acts in the same cycle, without any clock edge.
- R10: When `cfg_ap` is 1, `pt_ap` sets the state to 1 without any clock edge. When a clear and a preset are both active, the state becomes 0.
- R11: With `cfg_oreg`=1, `pad_out` shows the state after the edge. With `cfg_oreg`=0, it shows d as sampled at that edge.
- R12: `cfg_freg` chooses between the state and d for `fb_out` in the same way as R11, and independently of `cfg_oreg`.
- R13: `cfg_oe` drives `pad_oe`: 0 gives 0, 1 gives 1, 2 gives `oe_pin[0]`, 3 gives `oe_pin[1]`, 4 gives `io_in`, 5 gives `pt_oe`, and 6 or 7 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dsrc | input | 2 | Data source select |
| cfg_mode | input | 3 | Storage mode |
| cfg_csrc | input | CSW (2) | Cell clock source select |
| cfg_cen | input | 1 | Enables clock-enable gating |
| cfg_ar | input | 2 | Clear source enables (bit 0 global, bit 1 term) |
| cfg_ap | input | 1 | Preset term enable |
| cfg_oreg | input | 1 | Pad output registered (1) or combinational (0) |
| cfg_freg | input | 1 | Feedback registered (1) or combinational (0) |
| cfg_oe | input | OEW (3) | Output enable source select |
| xor_in | input | 1 | XOR result of the cell |
| pt_data | input | 1 | Separate data term |
| pt_k | input | 1 | Second data term (K or R) |
| pin_in | input | 1 | Pad input level |
| gclk | input | NGCK (3) | Global cell clocks |
| pt_clk | input | 1 | Term clock |
| pt_cen | input | 1 | Term clock enable |
| gclr | input | 1 | Global clear |
| pt_ar | input | 1 | Term clear |
| pt_ap | input | 1 | Term preset |
| oe_pin | input | NOE (2) | Dedicated output-enable pins |
| io_in | input | 1 | Enable taken from a pin used as input |
| pt_oe | input | 1 | Term output enable |
| pad_out | output | 1 | Pad data |
| pad_oe | output | 1 | Pad drive enable |
| fb_out | output | 1 | Buried feedback |

## Verification
The stored bit is visible only through `pad_out` or `fb_out` when either is set to registered. A wrong state therefore shows one `clk` edge after the cycle that corrupted it, provided the bench keeps a registered view selected. A missed or extra cell-clock edge, a gating error or a wrong clear or preset priority shows as a single wrong bit at that edge. In the flip-flop modes the error persists until the next capture that changes the state. A mistake in the combinational paths or in the enable selection affects only the edge that samples it. Each system cycle is compared against a reference model, so every error is caught at the first edge where it appears.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [2:0] MODE_D   = 3'd0;
  localparam logic [2:0] MODE_T   = 3'd1;
  localparam logic [2:0] MODE_JK  = 3'd2;
  localparam logic [2:0] MODE_SR  = 3'd3;
  localparam logic [2:0] MODE_LAT = 3'd4;

  localparam logic [1:0] DSRC_XOR = 2'd0;
  localparam logic [1:0] DSRC_PT  = 2'd1;
  localparam logic [1:0] DSRC_PIN = 2'd2;

  // Next state on a qualified rising edge for the flip-flop modes.
  function automatic logic edge_next(input logic [2:0] mode, input logic q,
                                     input logic a, input logic b);
    logic r;
    case (mode)
      MODE_T:  r = q ^ a;
      MODE_JK: r = (a & b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      MODE_SR: r = (a & ~b) ? 1'b1 : ((~a & b) ? 1'b0 : q);
      default: r = a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mc_dsel.sv
module mc_dsel (
  input  logic [1:0] dsrc,
  input  logic       xor_in,
  input  logic       pt_data,
  input  logic       pin_in,
  output logic       d
);
  import mc_pkg::*;

  always_comb begin
    case (dsrc)
      DSRC_PT:  d = pt_data;
      DSRC_PIN: d = pin_in;
      default:  d = xor_in;
    endcase
  end
endmodule

// File: rtl/mc_clkctl.sv
module mc_clkctl #(
  parameter int NGCK = 3,
  localparam int CSW = $clog2(NGCK + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NGCK-1:0] gclk,
  input  logic            pt_clk,
  input  logic [CSW-1:0]  csrc,
  input  logic            cen_en,
  input  logic            pt_cen,
  output logic            fire,
  output logic            open
);
  logic [NGCK:0] src_now;
  logic [NGCK:0] src_prev;
  logic          sel_now;
  logic          sel_prev;
  logic          use_pt;
  logic          cen_ok;

  assign src_now = {pt_clk, gclk};

  // Remember every source level so that a source change never fakes an edge.
  always_ff @(posedge clk) begin
    if (rst) src_prev <= '0;
    else     src_prev <= src_now;
  end

  always_comb begin
    sel_now  = pt_clk;
    sel_prev = src_prev[NGCK];
    for (int i = 0; i < NGCK; i++) begin
      if (csrc == CSW'(i)) begin
        sel_now  = gclk[i];
        sel_prev = src_prev[i];
      end
    end
  end

  assign use_pt = (csrc >= CSW'(NGCK));
  assign cen_ok = use_pt | ~cen_en | pt_cen;
  assign fire   = sel_now & ~sel_prev & cen_ok;
  assign open   = sel_now & cen_ok;
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       d,
  input  logic       k,
  input  logic       fire,
  input  logic       open,
  input  logic       clr,
  input  logic       pre,
  output logic       q,
  output logic       q_nxt
);
  import mc_pkg::*;

  always_comb begin
    q_nxt = q;
    if (clr)                  q_nxt = 1'b0;
    else if (pre)             q_nxt = 1'b1;
    else if (mode == MODE_LAT) begin
      if (open) q_nxt = d;
    end
    else if (fire)            q_nxt = edge_next(mode, q, d, k);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/mc_oectl.sv
module mc_oectl #(
  parameter int NOE = 2,
  localparam int OEW = $clog2(NOE + 4)
) (
  input  logic [OEW-1:0] sel,
  input  logic [NOE-1:0] oe_pin,
  input  logic           io_in,
  input  logic           pt_oe,
  output logic           oe
);
  localparam int CODE_IO = NOE + 2;
  localparam int CODE_PT = NOE + 3;

  logic [NOE-1:0] ded_hit;

  genvar g;
  generate
    for (g = 0; g < NOE; g++) begin : g_ded
      assign ded_hit[g] = (sel == OEW'(g + 2)) & oe_pin[g];
    end
  endgenerate

  always_comb begin
    oe = |ded_hit;
    if (sel == OEW'(1))       oe = 1'b1;
    if (sel == OEW'(CODE_IO)) oe = io_in;
    if (sel == OEW'(CODE_PT)) oe = pt_oe;
  end
endmodule

// File: rtl/mc_stage.sv
module mc_stage #(
  parameter int NGCK = 3,
  parameter int NOE  = 2,
  localparam int CSW = $clog2(NGCK + 1),
  localparam int OEW = $clog2(NOE + 4)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cfg_dsrc,
  input  logic [2:0]      cfg_mode,
  input  logic [CSW-1:0]  cfg_csrc,
  input  logic            cfg_cen,
  input  logic [1:0]      cfg_ar,
  input  logic            cfg_ap,
  input  logic            cfg_oreg,
  input  logic            cfg_freg,
  input  logic [OEW-1:0]  cfg_oe,
  input  logic            xor_in,
  input  logic            pt_data,
  input  logic            pt_k,
  input  logic            pin_in,
  input  logic [NGCK-1:0] gclk,
  input  logic            pt_clk,
  input  logic            pt_cen,
  input  logic            gclr,
  input  logic            pt_ar,
  input  logic            pt_ap,
  input  logic [NOE-1:0]  oe_pin,
  input  logic            io_in,
  input  logic            pt_oe,
  output logic            pad_out,
  output logic            pad_oe,
  output logic            fb_out
);
  logic d_sel;
  logic fire;
  logic open;
  logic clr_act;
  logic pre_act;
  logic st_q;
  logic st_nxt;
  logic oe_c;

  assign clr_act = (cfg_ar[0] & gclr) | (cfg_ar[1] & pt_ar);
  assign pre_act = cfg_ap & pt_ap;

  mc_dsel u_dsel (
    .dsrc(cfg_dsrc), .xor_in(xor_in), .pt_data(pt_data), .pin_in(pin_in), .d(d_sel)
  );

  mc_clkctl #(.NGCK(NGCK)) u_clk (
    .clk(clk), .rst(rst), .gclk(gclk), .pt_clk(pt_clk), .csrc(cfg_csrc),
    .cen_en(cfg_cen), .pt_cen(pt_cen), .fire(fire), .open(open)
  );

  mc_store u_store (
    .clk(clk), .rst(rst), .mode(cfg_mode), .d(d_sel), .k(pt_k), .fire(fire),
    .open(open), .clr(clr_act), .pre(pre_act), .q(st_q), .q_nxt(st_nxt)
  );

  mc_oectl #(.NOE(NOE)) u_oe (
    .sel(cfg_oe), .oe_pin(oe_pin), .io_in(io_in), .pt_oe(pt_oe), .oe(oe_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
      fb_out  <= 1'b0;
    end else begin
      pad_out <= cfg_oreg ? st_nxt : d_sel;
      pad_oe  <= oe_c;
      fb_out  <= cfg_freg ? st_nxt : d_sel;
    end
  end
endmodule

// File: rtl/mc_stage_chk.sv
module mc_stage_chk #(
  parameter int NGCK = 3,
  parameter int NOE  = 2,
  localparam int CSW = $clog2(NGCK + 1),
  localparam int OEW = $clog2(NOE + 4)
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      cfg_mode,
  input logic [CSW-1:0]  cfg_csrc,
  input logic            cfg_cen,
  input logic [1:0]      cfg_ar,
  input logic            cfg_ap,
  input logic [OEW-1:0]  cfg_oe,
  input logic [NGCK-1:0] gclk,
  input logic            pt_clk,
  input logic            pt_cen,
  input logic            gclr,
  input logic            pt_ar,
  input logic            pt_ap,
  input logic            pad_out,
  input logic            pad_oe,
  input logic            fb_out,
  input logic            st_q
);
  logic k_clr;
  logic k_pre;
  logic k_sel;
  logic k_glob;

  assign k_clr  = (cfg_ar[0] && gclr) || (cfg_ar[1] && pt_ar);
  assign k_pre  = cfg_ap && pt_ap;
  assign k_glob = (cfg_csrc < CSW'(NGCK));

  always_comb begin
    k_sel = pt_clk;
    for (int i = 0; i < NGCK; i++) if (cfg_csrc == CSW'(i)) k_sel = gclk[i];
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!pad_out && !pad_oe && !fb_out && !st_q));

  assert_clear_acts_R9: assert property (@(posedge clk) disable iff (rst)
    k_clr |=> !st_q);

  assert_preset_acts_R10: assert property (@(posedge clk) disable iff (rst)
    (k_pre && !k_clr) |=> st_q);

  assert_enable_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (!k_clr && !k_pre && k_glob && cfg_cen && !pt_cen) |=> $stable(st_q));

  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!k_clr && !k_pre && cfg_mode == 3'd4 && !k_sel) |=> $stable(st_q));

  assert_oe_on_R13: assert property (@(posedge clk) disable iff (rst)
    (cfg_oe == OEW'(1)) |=> pad_oe);

  assert_oe_off_R13: assert property (@(posedge clk) disable iff (rst)
    (cfg_oe == OEW'(0)) |=> !pad_oe);
endmodule

bind mc_stage mc_stage_chk #(.NGCK(NGCK), .NOE(NOE)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_csrc(cfg_csrc), .cfg_cen(cfg_cen),
  .cfg_ar(cfg_ar), .cfg_ap(cfg_ap), .cfg_oe(cfg_oe), .gclk(gclk), .pt_clk(pt_clk),
  .pt_cen(pt_cen), .gclr(gclr), .pt_ar(pt_ar), .pt_ap(pt_ap), .pad_out(pad_out),
  .pad_oe(pad_oe), .fb_out(fb_out), .st_q(st_q)
);

// File: tb/sim_mc_stage.sv
`timescale 1ns/1ps
module sim_mc_stage;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_dsrc;
  logic [2:0] cfg_mode;
  logic [1:0] cfg_csrc;
  logic       cfg_cen;
  logic [1:0] cfg_ar;
  logic       cfg_ap;
  logic       cfg_oreg;
  logic       cfg_freg;
  logic [2:0] cfg_oe;
  logic       xor_in, pt_data, pt_k, pin_in;
  logic [2:0] gclk;
  logic       pt_clk, pt_cen, gclr, pt_ar, pt_ap;
  logic [1:0] oe_pin;
  logic       io_in, pt_oe;
  logic       pad_out, pad_oe, fb_out;

  always #2.5 clk = ~clk;

  mc_stage u0 (
    .clk(clk), .rst(rst), .cfg_dsrc(cfg_dsrc), .cfg_mode(cfg_mode), .cfg_csrc(cfg_csrc),
    .cfg_cen(cfg_cen), .cfg_ar(cfg_ar), .cfg_ap(cfg_ap), .cfg_oreg(cfg_oreg),
    .cfg_freg(cfg_freg), .cfg_oe(cfg_oe), .xor_in(xor_in), .pt_data(pt_data),
    .pt_k(pt_k), .pin_in(pin_in), .gclk(gclk), .pt_clk(pt_clk), .pt_cen(pt_cen),
    .gclr(gclr), .pt_ar(pt_ar), .pt_ap(pt_ap), .oe_pin(oe_pin), .io_in(io_in),
    .pt_oe(pt_oe), .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic       m_q    = 1'b0;
  logic [3:0] m_prev = 4'b0;

  // Reference model built from the requirements; one expected item per system cycle.
  task automatic step(input string tag);
    logic d, cs, cp, ok, ar, ap, nq, oe;
    logic [3:0] src;
    src = {pt_clk, gclk};
    d   = (cfg_dsrc == 2'd1) ? pt_data : (cfg_dsrc == 2'd2) ? pin_in : xor_in;
    cs  = src[cfg_csrc];
    cp  = m_prev[cfg_csrc];
    ok  = (cfg_csrc == 2'd3) || !cfg_cen || pt_cen;
    ar  = (cfg_ar[0] && gclr) || (cfg_ar[1] && pt_ar);
    ap  = cfg_ap && pt_ap;
    nq  = m_q;
    if (ar) nq = 1'b0;
    else if (ap) nq = 1'b1;
    else if (cfg_mode == 3'd4) begin
      if (cs && ok) nq = d;
    end else if (cs && !cp && ok) begin
      case (cfg_mode)
        3'd1: nq = m_q ^ d;
        3'd2: nq = (d && pt_k) ? !m_q : d ? 1'b1 : pt_k ? 1'b0 : m_q;
        3'd3: nq = (d && !pt_k) ? 1'b1 : (!d && pt_k) ? 1'b0 : m_q;
        default: nq = d;
      endcase
    end
    case (cfg_oe)
      3'd1: oe = 1'b1;
      3'd2: oe = oe_pin[0];
      3'd3: oe = oe_pin[1];
      3'd4: oe = io_in;
      3'd5: oe = pt_oe;
      default: oe = 1'b0;
    endcase
    if (rst) begin
      exp_q.push_back(3'b000);
      m_q = 1'b0;
      m_prev = 4'b0;
    end else begin
      exp_q.push_back({cfg_oreg ? nq : d, oe, cfg_freg ? nq : d});
      m_q = nq;
      m_prev = src;
    end
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each result one time unit after the edge that produced it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({pad_out, pad_oe, fb_out} !== e) begin
          n_fail++;
          $display("FAIL %s: {pad_out,pad_oe,fb_out} got %b expected %b", t,
                   {pad_out, pad_oe, fb_out}, e);
        end
      end
    end
  end

  task automatic defaults();
    cfg_dsrc = 2'd0; cfg_mode = 3'd0; cfg_csrc = 2'd0; cfg_cen = 1'b0;
    cfg_ar = 2'd0; cfg_ap = 1'b0; cfg_oreg = 1'b1; cfg_freg = 1'b1; cfg_oe = 3'd1;
    xor_in = 0; pt_data = 0; pt_k = 0; pin_in = 0; gclk = 3'b0; pt_clk = 0;
    pt_cen = 0; gclr = 0; pt_ar = 0; pt_ap = 0; oe_pin = 2'b0; io_in = 0; pt_oe = 0;
  endtask

  // One cell-clock pulse (high cycle, then low cycle) on the selected source.
  task automatic pulse(input string tag);
    if (cfg_csrc == 2'd3) pt_clk = 1'b1; else gclk[cfg_csrc] = 1'b1;
    step(tag);
    if (cfg_csrc == 2'd3) pt_clk = 1'b0; else gclk[cfg_csrc] = 1'b0;
    step(tag);
  endtask

  initial begin
    defaults();
    @(negedge clk);
    // R1: reset with every input driven high
    {xor_in, pt_data, pt_k, pin_in, gclk, pt_clk, pt_cen, gclr, pt_ar, pt_ap} = '1;
    oe_pin = 2'b11; io_in = 1; pt_oe = 1;
    step("R1"); step("R1");
    defaults();
    rst = 1'b0;
    step("R1");

    // R3: D capture on each clock source, with the other clocks toggling
    for (int s = 0; s < 4; s++) begin
      cfg_csrc = 2'(s);
      for (int i = 0; i < 6; i++) begin
        xor_in = i[0] ^ i[1];
        gclk = ~gclk; pt_clk = ~pt_clk;
        step("R3");
        gclk = ~gclk; pt_clk = ~pt_clk;
        step("R3");
      end
    end
    gclk = 3'b0; pt_clk = 0; cfg_csrc = 2'd0;

    // R2, R11, R12: data source select in combinational and registered views
    for (int s = 0; s < 4; s++) begin
      cfg_dsrc = 2'(s);
      for (int v = 0; v < 8; v++) begin
        {xor_in, pt_data, pin_in} = 3'(v);
        cfg_oreg = v[0]; cfg_freg = ~v[0];
        step("R2");
      end
      pulse("R11");
    end
    cfg_dsrc = 2'd0; cfg_oreg = 1; cfg_freg = 0;
    xor_in = 1; pulse("R12");
    xor_in = 0; step("R12");
    cfg_oreg = 0; cfg_freg = 1; xor_in = 1; step("R11");

    // R4: T mode
    cfg_oreg = 1; cfg_mode = 3'd1;
    for (int i = 0; i < 6; i++) begin
      xor_in = (i != 2);
      pulse("R4");
    end

    // R5: JK, every J/K pair twice
    cfg_mode = 3'd2;
    for (int i = 0; i < 8; i++) begin
      xor_in = i[0]; pt_k = i[1];
      pulse("R5");
    end

    // R6: SR, and an unused mode code behaving as D
    cfg_mode = 3'd3;
    for (int i = 0; i < 8; i++) begin
      xor_in = i[1]; pt_k = i[0];
      pulse("R6");
    end
    cfg_mode = 3'd6; pt_k = 0;
    xor_in = 1; pulse("R6");
    xor_in = 0; pulse("R6");

    // R7: latch transparent while high, holding while low
    cfg_mode = 3'd4;
    gclk[0] = 1;
    for (int i = 0; i < 4; i++) begin xor_in = i[0]; step("R7"); end
    xor_in = 1; step("R7");
    gclk[0] = 0;
    for (int i = 0; i < 4; i++) begin xor_in = i[0]; step("R7"); end

    // R8: clock enable gating in D and latch mode, and ignored on the term clock
    cfg_cen = 1; pt_cen = 0;
    xor_in = 0; gclk[0] = 1; step("R8"); step("R8"); gclk[0] = 0; step("R8");
    cfg_mode = 3'd0;
    xor_in = 0; pt_cen = 1; pulse("R8");
    pt_cen = 0; xor_in = 1; pulse("R8"); pulse("R8");
    pt_cen = 1; pulse("R8");
    pt_cen = 0; cfg_csrc = 2'd3; xor_in = 0; pulse("R8");
    cfg_cen = 0; cfg_csrc = 2'd0;

    // R9: clear sources without a clock edge
    for (int a = 1; a < 4; a++) begin
      cfg_ar = 2'(a);
      for (int g = 0; g < 4; g++) begin
        xor_in = 1; pulse("R9");
        xor_in = 0;
        gclr = g[0]; pt_ar = g[1];
        step("R9");
        gclr = 0; pt_ar = 0;
        step("R9");
      end
    end
    cfg_ar = 2'd0; gclr = 1; pt_ar = 1; step("R9"); gclr = 0; pt_ar = 0;

    // R10: preset, disabled preset, and clear priority over preset
    xor_in = 0; pulse("R10");
    pt_ap = 1; step("R10");
    cfg_ap = 1; step("R10"); pt_ap = 0; step("R10");
    cfg_ar = 2'd1; gclr = 1; pt_ap = 1; step("R10");
    gclr = 0; step("R10"); pt_ap = 0; step("R10");
    cfg_ar = 2'd0; cfg_ap = 0;

    // R13: every enable code against every input pattern
    for (int c = 0; c < 8; c++) begin
      cfg_oe = 3'(c);
      for (int v = 0; v < 16; v++) begin
        {oe_pin, io_in, pt_oe} = 4'(v);
        step("R13");
      end
    end

    // R1: reset again from a non-zero state
    cfg_oe = 3'd1; xor_in = 1; pulse("R1");
    rst = 1; step("R1"); rst = 0; xor_in = 0; step("R1");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule